// File: doc/BRIEF.md
# Peak-Current PWM Sequencer

This block produces the gate-drive pulse train for a fixed-frequency converter that runs in peak-current mode. A free-running cycle timer marks the start of each switching period. At that strobe a new on-time begins, unless the quantised skip flag is raised. The on-time ends at the first current-sense trip seen after a blanking window, or at the maximum-duty limit, whichever comes first. While the gate is on, a ramp-connect enable tells the slope-compensation path to add its ramp.

Alongside the pulse path, a soft-start stepper raises a peak-setpoint code from zero to full scale over a programmable time. The code returns to zero whenever the supervisor removes the enable, so every start-up and every auto-recovery restart begins a fresh ramp. The analog comparators, the ramp summation and the setpoint DAC lie outside this block. The block sees only the digitised trip and skip flags and delivers only digital codes.

Top module: `pkpwm_sequencer`

## Requirements
- R1: While enabled, `cyc_start_o` is high for exactly one cycle every PERIOD_CYC cycles. The first strobe appears in the cycle after the first rising clock edge that samples `en_i` high.
- R2: If `skip_i` is low in a strobe cycle, `drv_o` goes high in the next cycle.
- R3: With no trip, `drv_o` stays high for exactly DMAX = PERIOD_CYC*DUTY_PCT/100 cycles (integer division). Cycle positions are numbered from 0 at the strobe, and the drive covers positions 1 to DMAX.
- R4: `trip_i` has no effect at positions 1 to LEB_CYC. A trip sampled at a later position p, while the drive is high, makes `drv_o` low from position p+1. A trip held high therefore gives an on-time of LEB_CYC+1 cycles.
- R5: If `skip_i` is high in a strobe cycle, no pulse occurs in that period. At all other positions `skip_i` has no effect, so a running on-time is never shortened by it.
- R6: At most one pulse occurs per period. Once a pulse has ended, `drv_o` stays low until the cycle after the next strobe, whatever the values of trip and skip.
- R7: `ramp_en_o` equals `drv_o` in every cycle.
- R8: If `en_i` is sampled low, then from the next cycle `drv_o` is low, `cyc_start_o` is low and `ss_code_o` is zero.
- R9: While enabled, `ss_code_o` rises by one every STEP = SS_CYC/(2^SS_W-1) cycles, starting from zero, and then holds at all ones. After n rising edges with `en_i` high, the code is min(n/STEP, 2^SS_W-1).
- R10: While reset is high, `drv_o`, `ramp_en_o` and `cyc_start_o` are low and `ss_code_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable from the supervisor |
| trip_i | input | 1 | Current-sense comparator trip, already digitised |
| skip_i | input | 1 | Skip-cycle request, already quantised from the feedback level |
| drv_o | output | 1 | Gate-drive pulse |
| ramp_en_o | output | 1 | Slope-ramp connect enable, active during the on-time |
| cyc_start_o | output | 1 | One-cycle strobe at the start of each period |
| ss_code_o | output | SS_W | Soft-start peak-setpoint code |

## Verification
The strobe appears one cycle after enable is first sampled. The drive rises one cycle after a strobe that sees skip low. It falls one cycle after a trip that is honoured, or after the clamp position. A disable is visible one cycle after it is sampled, and the soft-start code moves STEP edges after the previous step. The bench applies inputs just after a falling edge. A bench model built from these rules is advanced at the rising edge, and all four outputs are compared with it at the following falling edge. Directed cases then measure pulse widths, strobe spacing and pulses per period from those same samples.

// File: rtl/pkpwm_pkg.sv
package pkpwm_pkg;

    // width of the in-period position carried between sub-blocks
    localparam int unsigned POS_W = 16;

    typedef struct packed {
        logic             start;
        logic [POS_W-1:0] pos;
    } tick_t;

    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_BLANK = 2'd1,
        GATE_SENSE = 2'd2
    } gate_phase_e;

    // number of on-time cycles allowed by the duty clamp
    function automatic int unsigned duty_cycles(int unsigned period, int unsigned pct);
        return (period * pct) / 100;
    endfunction

    // clock cycles between soft-start code increments
    function automatic int unsigned ss_step(int unsigned total, int unsigned w);
        int unsigned s;
        s = total / ((1 << w) - 1);
        return (s == 0) ? 1 : s;
    endfunction

endpackage

// File: rtl/pkpwm_cycle_timer.sv
module pkpwm_cycle_timer #(
    parameter int unsigned PERIOD_CYC = 3077
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output pkpwm_pkg::tick_t tick_o
);
    import pkpwm_pkg::*;

    localparam int unsigned CNT_W = $clog2(PERIOD_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (!run_q || cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick_o.start = run_q && (cnt_q == '0);
    assign tick_o.pos   = POS_W'(cnt_q);

endmodule

// File: rtl/pkpwm_gate_ctrl.sv
module pkpwm_gate_ctrl #(
    parameter int unsigned PERIOD_CYC = 3077,
    parameter int unsigned DUTY_PCT   = 80,
    parameter int unsigned LEB_CYC    = 54
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  pkpwm_pkg::tick_t tick_i,
    input  logic             trip_i,
    input  logic             skip_i,
    output logic             drv_o
);
    import pkpwm_pkg::*;

    localparam int unsigned DMAX = duty_cycles(PERIOD_CYC, DUTY_PCT);
    localparam logic [POS_W-1:0] DMAX_P = POS_W'(DMAX);
    localparam logic [POS_W-1:0] LEB_P  = POS_W'(LEB_CYC);
    localparam gate_phase_e FIRST_PHASE = (LEB_CYC == 0) ? GATE_SENSE : GATE_BLANK;

    gate_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            GATE_OFF: begin
                // skip is looked at only here, at the period boundary
                if (tick_i.start && !skip_i) begin
                    phase_d = FIRST_PHASE;
                end
            end
            GATE_BLANK: begin
                // trip is masked while blanking
                if (tick_i.pos == DMAX_P) begin
                    phase_d = GATE_OFF;
                end else if (tick_i.pos == LEB_P) begin
                    phase_d = GATE_SENSE;
                end
            end
            GATE_SENSE: begin
                if (tick_i.pos == DMAX_P || trip_i) begin
                    phase_d = GATE_OFF;
                end
            end
            default: phase_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            phase_q <= GATE_OFF;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign drv_o = (phase_q != GATE_OFF);

endmodule

// File: rtl/pkpwm_softstart.sv
module pkpwm_softstart #(
    parameter int unsigned SS_CYC = 820000,
    parameter int unsigned SS_W   = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    output logic [SS_W-1:0] code_o
);
    import pkpwm_pkg::*;

    localparam int unsigned STEP = ss_step(SS_CYC, SS_W);
    localparam logic [SS_W-1:0] FULL = '1;

    logic            adv;
    logic [SS_W-1:0] code_q;

    if (STEP > 1) begin : g_pre
        localparam int unsigned PW = $clog2(STEP);
        localparam logic [PW-1:0] PRE_LAST = PW'(STEP - 1);
        logic [PW-1:0] pre_q;

        always_ff @(posedge clk_i) begin
            if (rst_i || !en_i) begin
                pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end

        assign adv = (pre_q == PRE_LAST);
    end else begin : g_nopre
        assign adv = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            code_q <= '0;
        end else if (adv && code_q != FULL) begin
            code_q <= code_q + 1'b1;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/pkpwm_sequencer.sv
module pkpwm_sequencer #(
    parameter int unsigned PERIOD_CYC = 3077,
    parameter int unsigned DUTY_PCT   = 80,
    parameter int unsigned LEB_CYC    = 54,
    parameter int unsigned SS_CYC     = 820000,
    parameter int unsigned SS_W       = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    input  logic            trip_i,
    input  logic            skip_i,
    output logic            drv_o,
    output logic            ramp_en_o,
    output logic            cyc_start_o,
    output logic [SS_W-1:0] ss_code_o
);
    import pkpwm_pkg::*;

    tick_t tick;
    logic  gate;

    pkpwm_cycle_timer #(
        .PERIOD_CYC(PERIOD_CYC)
    ) i_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .tick_o(tick)
    );

    pkpwm_gate_ctrl #(
        .PERIOD_CYC(PERIOD_CYC),
        .DUTY_PCT  (DUTY_PCT),
        .LEB_CYC   (LEB_CYC)
    ) i_gate (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .tick_i(tick),
        .trip_i(trip_i),
        .skip_i(skip_i),
        .drv_o (gate)
    );

    pkpwm_softstart #(
        .SS_CYC(SS_CYC),
        .SS_W  (SS_W)
    ) i_ss (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .code_o(ss_code_o)
    );

    assign drv_o       = gate;
    assign ramp_en_o   = gate;
    assign cyc_start_o = tick.start;

endmodule

// File: rtl/pkpwm_sva.sv
module pkpwm_sva #(
    parameter int unsigned PERIOD_CYC = 3077,
    parameter int unsigned DUTY_PCT   = 80,
    parameter int unsigned LEB_CYC    = 54,
    parameter int unsigned SS_W       = 8
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            en_i,
    input logic            skip_i,
    input logic            drv_o,
    input logic            cyc_start_o,
    input logic [SS_W-1:0] ss_code_o
);
    import pkpwm_pkg::*;

    localparam int unsigned DMAX = duty_cycles(PERIOD_CYC, DUTY_PCT);

    // consecutive high cycles of the drive seen so far
    logic [15:0] hi_len;

    always_ff @(posedge clk_i) begin
        if (rst_i || !drv_o) begin
            hi_len <= '0;
        end else begin
            hi_len <= hi_len + 1'b1;
        end
    end

    a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        cyc_start_o |=> !cyc_start_o);

    a_r2_start_fires: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_start_o && !skip_i && en_i) |=> drv_o);

    a_r3_clamp: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_o |-> (32'(hi_len) < DMAX));

    a_r4_min_on: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(drv_o) && $past(en_i)) |-> (32'($past(hi_len)) >= LEB_CYC));

    a_r5_skip_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_start_o && skip_i) |=> !drv_o);

    a_r6_rise_on_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(drv_o) |-> $past(cyc_start_o));

    a_r8_disable_drive: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!drv_o && !cyc_start_o));

    a_r8_disable_code: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (ss_code_o == '0));

    a_r9_code_step: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) |-> (ss_code_o == $past(ss_code_o) || ss_code_o == $past(ss_code_o) + 1'b1));

endmodule

bind pkpwm_sequencer pkpwm_sva #(
    .PERIOD_CYC(PERIOD_CYC),
    .DUTY_PCT  (DUTY_PCT),
    .LEB_CYC   (LEB_CYC),
    .SS_W      (SS_W)
) i_sva (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .skip_i     (skip_i),
    .drv_o      (drv_o),
    .cyc_start_o(cyc_start_o),
    .ss_code_o  (ss_code_o)
);

// File: tb/test_pkpwm_sequencer.sv
`timescale 1ns/1ps
module test_pkpwm_sequencer;
    localparam int P    = 40;
    localparam int DUTY = 80;
    localparam int LEB  = 4;
    localparam int SSC  = 150;
    localparam int SW   = 4;
    localparam int DMAX = P * DUTY / 100;
    localparam int CMAX = (1 << SW) - 1;
    localparam int STEP = SSC / CMAX;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic trip = 1'b0;
    logic skip = 1'b0;
    logic drv, ramp, start;
    logic [SW-1:0] code;

    pkpwm_sequencer #(
        .PERIOD_CYC(P), .DUTY_PCT(DUTY), .LEB_CYC(LEB), .SS_CYC(SSC), .SS_W(SW)
    ) i_pkpwm_sequencer (
        .clk_i(clk), .rst_i(rst), .en_i(en), .trip_i(trip), .skip_i(skip),
        .drv_o(drv), .ramp_en_o(ramp), .cyc_start_o(start), .ss_code_o(code)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference state
    int m_run = 0, m_cnt = 0, m_drv = 0, m_pre = 0, m_code = 0;
    // observation trackers
    int run_len = 0, last_w = 0, rises = 0, gap = 0, last_gap = 0;
    bit prev_drv = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int st, nd;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_drv = 0; m_pre = 0; m_code = 0;
        end else begin
            st = (m_run != 0 && m_cnt == 0) ? 1 : 0;
            if (!en) nd = 0;
            else if (st != 0 && !skip) nd = 1;
            else if (m_drv != 0 && (m_cnt == DMAX || (trip && m_cnt > LEB))) nd = 0;
            else nd = m_drv;
            m_drv = nd;
            if (!en) begin
                m_run = 0; m_cnt = 0; m_pre = 0; m_code = 0;
            end else begin
                m_cnt = (m_run == 0 || m_cnt == P - 1) ? 0 : m_cnt + 1;
                m_run = 1;
                if (m_pre == STEP - 1) begin
                    m_pre = 0;
                    if (m_code < CMAX) m_code++;
                end else begin
                    m_pre++;
                end
            end
        end
    endtask

    task automatic cyc(input bit e, input bit s, input bit t);
        en = e; skip = s; trip = t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 R3 R4 R5 drive", int'(drv), m_drv);
        chk("R7 ramp", int'(ramp), int'(drv));
        chk("R1 strobe", int'(start), (m_run != 0 && m_cnt == 0) ? 1 : 0);
        chk("R9 code", int'(code), m_code);
        if (drv && !prev_drv) rises++;
        if (drv) run_len++;
        else if (run_len != 0) begin last_w = run_len; run_len = 0; end
        prev_drv = drv;
        gap++;
        if (start) begin last_gap = gap; gap = 0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        void'($urandom(32'd4711));
        rst = 1'b1;
        repeat (3) cyc(0, 0, 0);
        chk("R10 drive in reset", int'(drv), 0);
        chk("R10 strobe in reset", int'(start), 0);
        chk("R10 code in reset", int'(code), 0);
        rst = 1'b0;

        // first strobe one cycle after enable
        cyc(1, 0, 0);
        chk("R1 first strobe", int'(start), 1);
        repeat (3 * P) cyc(1, 0, 0);
        chk("R3 clamped width", last_w, DMAX);
        chk("R1 strobe spacing", last_gap, P);

        // trip held high: only blanking protects the on-time
        repeat (2 * P) cyc(1, 0, 1);
        chk("R4 width with constant trip", last_w, LEB + 1);

        // trip only inside the blanking window
        repeat (2 * P) cyc(1, 0, (m_cnt >= 1 && m_cnt <= LEB));
        chk("R4 trip in blank ignored", last_w, DMAX);

        // trip from position 20 to end of period
        r0 = rises;
        repeat (2 * P) cyc(1, 0, (m_cnt >= 20));
        chk("R4 trip ends pulse", last_w, 20);
        chk("R6 one pulse per period", rises - r0, 2);

        // skip held high: no pulses
        r0 = rises;
        repeat (2 * P) cyc(1, 1, 0);
        chk("R5 skip suppresses", rises - r0, 0);

        // skip raised only inside the on-time
        repeat (2 * P) cyc(1, (m_cnt >= 5 && m_cnt <= 10), 0);
        chk("R5 skip mid pulse ignored", last_w, DMAX);

        // disable in the middle of a pulse
        while (!(m_drv != 0 && m_cnt == 10)) cyc(1, 0, 0);
        cyc(0, 0, 0);
        chk("R8 drive off", int'(drv), 0);
        chk("R8 code cleared", int'(code), 0);
        chk("R8 strobe off", int'(start), 0);

        // soft-start ramp
        cyc(1, 0, 0);
        repeat (STEP - 1) cyc(1, 0, 0);
        chk("R9 first step", int'(code), 1);
        repeat (STEP * (CMAX - 1)) cyc(1, 0, 0);
        chk("R9 full scale", int'(code), CMAX);
        repeat (2 * STEP) cyc(1, 0, 0);
        chk("R9 holds at full scale", int'(code), CMAX);
        cyc(0, 0, 0);
        repeat (3) cyc(1, 0, 0);
        chk("R9 restart from zero", int'(code), 0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 200) != 0, ($urandom % 4) == 0, ($urandom % 8) == 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule